// File: doc/BRIEF.md
# Multi-width aliased vector register file

This block is a SIMD register file that keeps its contents in one array of rows. Each row holds `LANES` lanes of `LW` bits. The same rows can be read and written through three register classes of different widths:

- **Narrow class:** one narrow register is exactly one row.
- **Double class:** one double register joins two neighbouring rows, so each lane is `2*LW` bits wide.
- **Quad class:** one quad register joins four neighbouring rows, so each lane is `4*LW` bits wide.

Because every class works on the same rows, a narrow result, a double-width result and a quad-width accumulator result can be exchanged with no copying.

Each class has its own parameterised number of read ports and write ports. Reads are combinational and give data in the same cycle as the address. Writes are stored at the rising clock edge. A separate narrow-width port, for test access, can also read and write single rows.

Several writes can land on one row in the same cycle. The next value of that row is chosen by a fixed class order. Within one class, the port with the higher number wins.

There is no controller state, so the block has no state machine. Its only sequential element is the row array, which has a synchronous reset.

Top module: `mwrf_top`

## Requirements
- R1: While `rst` is high at a rising edge, every row is cleared. After that edge, every read port returns zero until some write occurs.
- R2: A narrow read port `p` returns row `vx_ra[p]` combinationally. Lane `j` is at bits `[j*LW +: LW]`.
- R3: A double read port at address `a` returns lane `j` at bits `[j*2*LW +: 2*LW]`. Row `2a` supplies the low `LW` bits of each lane and row `2a+1` supplies the high `LW` bits.
- R4: A quad read port at address `a` returns lane `j` at bits `[j*4*LW +: 4*LW]`. Row `4a+k` supplies bits `[k*LW +: LW]` of each lane, for `k` from 0 to 3.
- R5: A write takes effect at the rising edge only when its enable is high. A row that no enabled port targets keeps its contents, whatever the data and address inputs hold.
- R6: A double or quad write updates all of its covered rows at the same edge. Covered row `2a+h` takes slice `h`, and covered row `4a+k` takes slice `k`, of every lane.
- R7: When classes collide on a row in one cycle, the row takes the data of the highest-ranked class present: quad first, then double, then narrow, then the external port. A wide write that loses some rows still lands on the other rows it covers.
- R8: When two write ports of the same class target the same register in one cycle, the higher-numbered port wins.
- R9: A read in the cycle of a write to the same row returns the value held before that edge.
- R10: The external port reads and writes one row at narrow width, with the same lane layout as R2, and ranks lowest in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are stored on its rising edge |
| rst | input | 1 | Synchronous reset; clears every row |
| vx_ra | input | NXR*log2(ROWS) | Narrow read addresses, one per port |
| vx_rd | output | NXR*LANES*LW | Narrow read data, one row per port |
| vx_we | input | NXW | Narrow write enables |
| vx_wa | input | NXW*log2(ROWS) | Narrow write addresses |
| vx_wd | input | NXW*LANES*LW | Narrow write data |
| ve_ra | input | NER*log2(ROWS/2) | Double read addresses |
| ve_rd | output | NER*LANES*2*LW | Double read data |
| ve_we | input | NEW | Double write enables |
| ve_wa | input | NEW*log2(ROWS/2) | Double write addresses |
| ve_wd | input | NEW*LANES*2*LW | Double write data |
| vr_ra | input | NQR*log2(ROWS/4) | Quad read addresses |
| vr_rd | output | NQR*LANES*4*LW | Quad read data |
| vr_we | input | NQW | Quad write enables |
| vr_wa | input | NQW*log2(ROWS/4) | Quad write addresses |
| vr_wd | input | NQW*LANES*4*LW | Quad write data |
| ext_ra | input | log2(ROWS) | External read address |
| ext_rd | output | LANES*LW | External read data |
| ext_we | input | 1 | External write enable |
| ext_wa | input | log2(ROWS) | External write address |
| ext_wd | input | LANES*LW | External write data |

## Verification
Directed patterns drive one wide write at a time and read back through all views. Any swapped lane or slice in the alias mapping then shows up as a mismatch on a specific row.

A staged collision writes four classes into overlapping rows in one cycle. This separates a correct per-row priority from one that is applied per register or in reverse order. Same-port-class collisions check the port-order rule in the same way.

Cycles with full data but all enables low expose any write that ignores its enable. Long random runs confine the addresses to a few rows so that collisions across classes happen often. Every read port is compared on every clock against a byte-level model, which also covers reads made in the same cycle as a write.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

    // Which write source decided a row's next value (ascending rank)
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXT,
        SRC_VX,
        SRC_VE,
        SRC_VR
    } wr_src_e;

endpackage

// File: rtl/mwrf_view_rd.sv
module mwrf_view_rd #(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int LW    = 8,
    parameter int MULT  = 1,
    parameter int NPORT = 1,
    localparam int REGS = ROWS / MULT,
    localparam int AW   = (REGS > 1) ? $clog2(REGS) : 1,
    localparam int RAW  = $clog2(ROWS),
    localparam int RW   = LANES * LW,
    localparam int EW   = MULT * LW
) (
    input  logic [ROWS-1:0][RW-1:0]         rows_i,
    input  logic [NPORT-1:0][AW-1:0]        addr_i,
    output logic [NPORT-1:0][LANES*EW-1:0]  data_o
);

    always_comb begin
        logic [RAW-1:0] idx;
        data_o = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int k = 0; k < MULT; k++) begin
                idx = RAW'(int'(addr_i[p]) * MULT + k);
                for (int j = 0; j < LANES; j++) begin
                    data_o[p][j*EW + k*LW +: LW] = rows_i[idx][j*LW +: LW];
                end
            end
        end
    end

endmodule

// File: rtl/mwrf_row_next.sv
module mwrf_row_next
    import mwrf_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int LW    = 8,
    parameter int NXW   = 2,
    parameter int NEW   = 1,
    parameter int NQW   = 2,
    localparam int AXW  = $clog2(ROWS),
    localparam int AEW  = $clog2(ROWS / 2),
    localparam int AQW  = $clog2(ROWS / 4),
    localparam int RW   = LANES * LW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ROWS-1:0][RW-1:0]     rows_i,
    input  logic                        ext_we,
    input  logic [AXW-1:0]              ext_wa,
    input  logic [RW-1:0]               ext_wd,
    input  logic [NXW-1:0]              vx_we,
    input  logic [NXW-1:0][AXW-1:0]     vx_wa,
    input  logic [NXW-1:0][RW-1:0]      vx_wd,
    input  logic [NEW-1:0]              ve_we,
    input  logic [NEW-1:0][AEW-1:0]     ve_wa,
    input  logic [NEW-1:0][2*RW-1:0]    ve_wd,
    input  logic [NQW-1:0]              vr_we,
    input  logic [NQW-1:0][AQW-1:0]     vr_wa,
    input  logic [NQW-1:0][4*RW-1:0]    vr_wd,
    output logic [ROWS-1:0][RW-1:0]     rows_nxt_o,
    output wr_src_e                     src_o [ROWS]
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int HALF = r % 2;
        localparam int QTR  = r % 4;

        logic            ext_hit;
        logic [NXW-1:0]  vx_hit;
        logic [NEW-1:0]  ve_hit;
        logic [NQW-1:0]  vr_hit;
        logic [RW-1:0]   nxt_r;
        wr_src_e         src_r;

        always_comb begin
            ext_hit = ext_we && (ext_wa == AXW'(r));
            for (int p = 0; p < NXW; p++) vx_hit[p] = vx_we[p] && (vx_wa[p] == AXW'(r));
            for (int p = 0; p < NEW; p++) ve_hit[p] = ve_we[p] && (ve_wa[p] == AEW'(r / 2));
            for (int p = 0; p < NQW; p++) vr_hit[p] = vr_we[p] && (vr_wa[p] == AQW'(r / 4));
        end

        // Sources applied lowest rank first; each later one overrides
        always_comb begin
            nxt_r = rows_i[r];
            src_r = SRC_NONE;
            if (ext_hit) begin
                nxt_r = ext_wd;
                src_r = SRC_EXT;
            end
            for (int p = 0; p < NXW; p++) begin
                if (vx_hit[p]) begin
                    nxt_r = vx_wd[p];
                    src_r = SRC_VX;
                end
            end
            for (int p = 0; p < NEW; p++) begin
                if (ve_hit[p]) begin
                    for (int j = 0; j < LANES; j++)
                        nxt_r[j*LW +: LW] = ve_wd[p][j*2*LW + HALF*LW +: LW];
                    src_r = SRC_VE;
                end
            end
            for (int p = 0; p < NQW; p++) begin
                if (vr_hit[p]) begin
                    for (int j = 0; j < LANES; j++)
                        nxt_r[j*LW +: LW] = vr_wd[p][j*4*LW + QTR*LW +: LW];
                    src_r = SRC_VR;
                end
            end
        end

        assign rows_nxt_o[r] = nxt_r;
        assign src_o[r]      = src_r;

        // R7
        quad_rank_chk: assert property (@(posedge clk) disable iff (rst)
            (|vr_hit) |-> (src_r == SRC_VR));

        // R7
        double_rank_chk: assert property (@(posedge clk) disable iff (rst)
            ((|ve_hit) && !(|vr_hit)) |-> (src_r == SRC_VE));

        // R10
        ext_lowest_chk: assert property (@(posedge clk) disable iff (rst)
            ((|vx_hit) || (|ve_hit) || (|vr_hit)) |-> (src_r != SRC_EXT));
    end

endmodule

// File: rtl/mwrf_top.sv
module mwrf_top
    import mwrf_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int LANES = 8,
    parameter int LW    = 8,
    parameter int NXR   = 4,
    parameter int NXW   = 2,
    parameter int NER   = 2,
    parameter int NEW   = 1,
    parameter int NQR   = 2,
    parameter int NQW   = 2,
    localparam int AXW  = $clog2(ROWS),
    localparam int AEW  = $clog2(ROWS / 2),
    localparam int AQW  = $clog2(ROWS / 4),
    localparam int RW   = LANES * LW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NXR-1:0][AXW-1:0]     vx_ra,
    output logic [NXR-1:0][RW-1:0]      vx_rd,
    input  logic [NXW-1:0]              vx_we,
    input  logic [NXW-1:0][AXW-1:0]     vx_wa,
    input  logic [NXW-1:0][RW-1:0]      vx_wd,
    input  logic [NER-1:0][AEW-1:0]     ve_ra,
    output logic [NER-1:0][2*RW-1:0]    ve_rd,
    input  logic [NEW-1:0]              ve_we,
    input  logic [NEW-1:0][AEW-1:0]     ve_wa,
    input  logic [NEW-1:0][2*RW-1:0]    ve_wd,
    input  logic [NQR-1:0][AQW-1:0]     vr_ra,
    output logic [NQR-1:0][4*RW-1:0]    vr_rd,
    input  logic [NQW-1:0]              vr_we,
    input  logic [NQW-1:0][AQW-1:0]     vr_wa,
    input  logic [NQW-1:0][4*RW-1:0]    vr_wd,
    input  logic [AXW-1:0]              ext_ra,
    output logic [RW-1:0]               ext_rd,
    input  logic                        ext_we,
    input  logic [AXW-1:0]              ext_wa,
    input  logic [RW-1:0]               ext_wd
);

    logic [ROWS-1:0][RW-1:0] rows_q;
    logic [ROWS-1:0][RW-1:0] rows_nxt;
    wr_src_e                 row_src [ROWS];

    always_ff @(posedge clk) begin
        if (rst) rows_q <= '0;
        else     rows_q <= rows_nxt;
    end

    mwrf_row_next #(
        .ROWS(ROWS), .LANES(LANES), .LW(LW),
        .NXW(NXW), .NEW(NEW), .NQW(NQW)
    ) u_row_next (
        .clk(clk), .rst(rst), .rows_i(rows_q),
        .ext_we(ext_we), .ext_wa(ext_wa), .ext_wd(ext_wd),
        .vx_we(vx_we), .vx_wa(vx_wa), .vx_wd(vx_wd),
        .ve_we(ve_we), .ve_wa(ve_wa), .ve_wd(ve_wd),
        .vr_we(vr_we), .vr_wa(vr_wa), .vr_wd(vr_wd),
        .rows_nxt_o(rows_nxt), .src_o(row_src)
    );

    mwrf_view_rd #(.ROWS(ROWS), .LANES(LANES), .LW(LW), .MULT(1), .NPORT(NXR))
        u_vx_rd (.rows_i(rows_q), .addr_i(vx_ra), .data_o(vx_rd));

    mwrf_view_rd #(.ROWS(ROWS), .LANES(LANES), .LW(LW), .MULT(2), .NPORT(NER))
        u_ve_rd (.rows_i(rows_q), .addr_i(ve_ra), .data_o(ve_rd));

    mwrf_view_rd #(.ROWS(ROWS), .LANES(LANES), .LW(LW), .MULT(4), .NPORT(NQR))
        u_vr_rd (.rows_i(rows_q), .addr_i(vr_ra), .data_o(vr_rd));

    mwrf_view_rd #(.ROWS(ROWS), .LANES(LANES), .LW(LW), .MULT(1), .NPORT(1))
        u_ext_rd (.rows_i(rows_q), .addr_i(ext_ra), .data_o(ext_rd));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((ext_rd == '0) && (vr_rd == '0) && (ve_rd == '0)));

    for (genvar r = 0; r < ROWS; r++) begin : g_hold
        // R5
        idle_row_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (row_src[r] == SRC_NONE) |=> $stable(rows_q[r]));
    end

endmodule

// File: tb/mwrf_top_tb_top.sv
module mwrf_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 32, LANES = 8, LW = 8;
    localparam int NXR = 4, NXW = 2, NER = 2, NEW = 1, NQR = 2, NQW = 2;
    localparam int AXW = $clog2(ROWS), AEW = $clog2(ROWS/2), AQW = $clog2(ROWS/4);
    localparam int RW = LANES * LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NXR*AXW-1:0]  vx_ra;
    logic [NXR*RW-1:0]   vx_rd;
    logic [NXW-1:0]      vx_we;
    logic [NXW*AXW-1:0]  vx_wa;
    logic [NXW*RW-1:0]   vx_wd;
    logic [NER*AEW-1:0]  ve_ra;
    logic [NER*2*RW-1:0] ve_rd;
    logic [NEW-1:0]      ve_we;
    logic [NEW*AEW-1:0]  ve_wa;
    logic [NEW*2*RW-1:0] ve_wd;
    logic [NQR*AQW-1:0]  vr_ra;
    logic [NQR*4*RW-1:0] vr_rd;
    logic [NQW-1:0]      vr_we;
    logic [NQW*AQW-1:0]  vr_wa;
    logic [NQW*4*RW-1:0] vr_wd;
    logic [AXW-1:0]      ext_ra;
    logic [RW-1:0]       ext_rd;
    logic                ext_we;
    logic [AXW-1:0]      ext_wa;
    logic [RW-1:0]       ext_wd;

    int vectors = 0;
    int miscompares = 0;
    logic [LW-1:0] mdl [ROWS][LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwrf_top dut_i (
        .clk(clk), .rst(rst),
        .vx_ra(vx_ra), .vx_rd(vx_rd), .vx_we(vx_we), .vx_wa(vx_wa), .vx_wd(vx_wd),
        .ve_ra(ve_ra), .ve_rd(ve_rd), .ve_we(ve_we), .ve_wa(ve_wa), .ve_wd(ve_wd),
        .vr_ra(vr_ra), .vr_rd(vr_rd), .vr_we(vr_we), .vr_wa(vr_wa), .vr_wd(vr_wd),
        .ext_ra(ext_ra), .ext_rd(ext_rd), .ext_we(ext_we), .ext_wa(ext_wa), .ext_wd(ext_wd)
    );

    task automatic compare(string tag, string req, int port, logic [4*RW-1:0] act, logic [4*RW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s/%s port %0d: actual %h expected %h", tag, req, port, act, exp);
        end
    endtask

    // Compare every read port against the model (state before the next edge)
    task automatic check_all(string tag);
        logic [4*RW-1:0] e;
        for (int p = 0; p < NXR; p++) begin
            int a = int'(vx_ra[p*AXW +: AXW]);
            e = '0;
            for (int j = 0; j < LANES; j++) e[j*LW +: LW] = mdl[a][j];
            compare(tag, "R2", p, {{(3*RW){1'b0}}, vx_rd[p*RW +: RW]}, e);
        end
        for (int p = 0; p < NER; p++) begin
            int a = int'(ve_ra[p*AEW +: AEW]);
            e = '0;
            for (int j = 0; j < LANES; j++)
                for (int h = 0; h < 2; h++) e[j*2*LW + h*LW +: LW] = mdl[2*a+h][j];
            compare(tag, "R3", p, {{(2*RW){1'b0}}, ve_rd[p*2*RW +: 2*RW]}, e);
        end
        for (int p = 0; p < NQR; p++) begin
            int a = int'(vr_ra[p*AQW +: AQW]);
            e = '0;
            for (int j = 0; j < LANES; j++)
                for (int k = 0; k < 4; k++) e[j*4*LW + k*LW +: LW] = mdl[4*a+k][j];
            compare(tag, "R4", p, vr_rd[p*4*RW +: 4*RW], e);
        end
        e = '0;
        for (int j = 0; j < LANES; j++) e[j*LW +: LW] = mdl[int'(ext_ra)][j];
        compare(tag, "R10", 0, {{(3*RW){1'b0}}, ext_rd}, e);
    endtask

    // Reference update: lowest rank first, ports in ascending order
    task automatic model_edge();
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int j = 0; j < LANES; j++) mdl[r][j] = '0;
            return;
        end
        if (ext_we)
            for (int j = 0; j < LANES; j++) mdl[int'(ext_wa)][j] = ext_wd[j*LW +: LW];
        for (int p = 0; p < NXW; p++)
            if (vx_we[p])
                for (int j = 0; j < LANES; j++)
                    mdl[int'(vx_wa[p*AXW +: AXW])][j] = vx_wd[p*RW + j*LW +: LW];
        for (int p = 0; p < NEW; p++)
            if (ve_we[p])
                for (int h = 0; h < 2; h++)
                    for (int j = 0; j < LANES; j++)
                        mdl[2*int'(ve_wa[p*AEW +: AEW])+h][j] = ve_wd[p*2*RW + j*2*LW + h*LW +: LW];
        for (int p = 0; p < NQW; p++)
            if (vr_we[p])
                for (int k = 0; k < 4; k++)
                    for (int j = 0; j < LANES; j++)
                        mdl[4*int'(vr_wa[p*AQW +: AQW])+k][j] = vr_wd[p*4*RW + j*4*LW + k*LW +: LW];
    endtask

    task automatic cycle(string tag);
        #1 check_all(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        vx_we = '0; ve_we = '0; vr_we = '0; ext_we = 1'b0;
    endtask

    task automatic rand_data();
        for (int b = 0; b < NXW*RW; b += 32)   vx_wd[b +: 32] = $urandom;
        for (int b = 0; b < NEW*2*RW; b += 32) ve_wd[b +: 32] = $urandom;
        for (int b = 0; b < NQW*4*RW; b += 32) vr_wd[b +: 32] = $urandom;
        for (int b = 0; b < RW; b += 32)       ext_wd[b +: 32] = $urandom;
    endtask

    // narrow != 0 confines addresses to rows 0..7 to force collisions
    task automatic rand_all(bit narrow);
        rand_data();
        for (int p = 0; p < NXR; p++) vx_ra[p*AXW +: AXW] = AXW'(narrow ? $urandom % 8 : $urandom);
        for (int p = 0; p < NER; p++) ve_ra[p*AEW +: AEW] = AEW'(narrow ? $urandom % 4 : $urandom);
        for (int p = 0; p < NQR; p++) vr_ra[p*AQW +: AQW] = AQW'(narrow ? $urandom % 2 : $urandom);
        ext_ra = AXW'(narrow ? $urandom % 8 : $urandom);
        for (int p = 0; p < NXW; p++) vx_wa[p*AXW +: AXW] = AXW'(narrow ? $urandom % 8 : $urandom);
        for (int p = 0; p < NEW; p++) ve_wa[p*AEW +: AEW] = AEW'(narrow ? $urandom % 4 : $urandom);
        for (int p = 0; p < NQW; p++) vr_wa[p*AQW +: AQW] = AQW'(narrow ? $urandom % 2 : $urandom);
        ext_wa = AXW'(narrow ? $urandom % 8 : $urandom);
        vx_we = NXW'($urandom); ve_we = NEW'($urandom); vr_we = NQW'($urandom);
        ext_we = 1'($urandom);
    endtask

    task automatic sweep_reads(string tag, int rows);
        idle();
        for (int s = 0; s < rows; s += 4) begin
            for (int p = 0; p < NXR; p++) vx_ra[p*AXW +: AXW] = AXW'(s + p);
            for (int p = 0; p < NER; p++) ve_ra[p*AEW +: AEW] = AEW'(s/2 + p);
            for (int p = 0; p < NQR; p++) vr_ra[p*AQW +: AQW] = AQW'(s/4);
            ext_ra = AXW'(s + 3);
            cycle(tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int j = 0; j < LANES; j++) mdl[r][j] = 'x;
        vx_ra = '0; ve_ra = '0; vr_ra = '0; ext_ra = '0;
        vx_wa = '0; ve_wa = '0; vr_wa = '0; ext_wa = '0;
        idle(); rand_data();
        @(negedge clk);
        // R1: reset with writes requested still clears everything
        rst = 1'b1;
        rand_all(1'b0);
        @(posedge clk); model_edge(); @(negedge clk);
        @(posedge clk); model_edge(); @(negedge clk);
        rst = 1'b0;
        sweep_reads("R1", ROWS);

        // R6: one quad write, then read all views of its rows
        rand_data(); vr_wa[0 +: AQW] = AQW'(3); vr_we = 2'b01;
        cycle("R6");
        sweep_reads("R6", ROWS);

        // R6: one double write
        rand_data(); idle(); ve_wa = AEW'(5); ve_we = 1'b1;
        cycle("R6");
        sweep_reads("R6", ROWS);

        // R7: four classes collide on rows 4..7 and row 9
        rand_data(); idle();
        vr_wa[0 +: AQW] = AQW'(1); vr_we = 2'b01;
        ve_wa = AEW'(2); ve_we = 1'b1;
        vx_wa = {AXW'(9), AXW'(5)}; vx_we = 2'b11;
        ext_wa = AXW'(9); ext_we = 1'b1;
        cycle("R7");
        sweep_reads("R7", 12);
        // R7: double vs narrow vs external on row 10, double survives on 11
        rand_data(); idle();
        ve_wa = AEW'(5); ve_we = 1'b1;
        vx_wa = {AXW'(10), AXW'(11)}; vx_we = 2'b11;
        ext_wa = AXW'(10); ext_we = 1'b1;
        cycle("R7");
        sweep_reads("R7", 12);

        // R8: same-class port collisions
        rand_data(); idle();
        vx_wa = {AXW'(20), AXW'(20)}; vx_we = 2'b11;
        vr_wa = {AQW'(6), AQW'(6)};  vr_we = 2'b11;
        cycle("R8");
        sweep_reads("R8", ROWS);

        // R9: read the rows being written in the same cycle
        rand_data(); idle();
        vx_ra = {AXW'(3), AXW'(2), AXW'(1), AXW'(0)};
        vr_ra = {AQW'(0), AQW'(0)};
        vr_wa[0 +: AQW] = AQW'(0); vr_we = 2'b01;
        cycle("R9");
        cycle("R9");

        // R5: data and addresses toggle with every enable low
        for (int i = 0; i < 8; i++) begin
            rand_all(1'b0); idle();
            cycle("R5");
        end
        sweep_reads("R5", ROWS);

        // R10: external write alone, read back on both narrow paths
        rand_data(); idle(); ext_wa = AXW'(30); ext_we = 1'b1;
        cycle("R10");
        idle(); ext_ra = AXW'(30); vx_ra[0 +: AXW] = AXW'(30);
        cycle("R10");

        // Random mixed-width traffic, mostly confined for collisions
        for (int i = 0; i < 3000; i++) begin
            rand_all(($urandom % 4) != 0);
            cycle("R7");
        end
        sweep_reads("R5", ROWS);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule